// File: doc/BRIEF.md
# A/D Conversion Start and Completion Sequencer

This block is the digital control half of a successive-approximation analog-to-digital converter inside a microcontroller. Software writes a start bit and a three-bit clock-select field through a simple write port. The block recognises a start request only when the start bit has been raised and then lowered again. It derives a conversion clock from the system clock through a selectable power-of-two prescaler. It then steps through a fixed twelve-period conversion: one sampling period, ten bit decisions taken most significant bit first, and one finishing period.

Completion is reported in three ways. An active-low status bit reads high while a conversion is pending and drops when the conversion is done. A sticky interrupt-request flag is set at the same moment. A one-cycle capture strobe is also raised. The interrupt output follows the flag only when the enable input is high. A further output warns when the selected division gives a conversion-clock period below the allowed minimum for the system clock frequency set as a parameter. The comparator lives in the analog core and feeds one result bit per decision period.

Top module: `adc_seq_ctrl`

## Requirements
- R1: A conversion starts only after the start bit is written 1 and then written 0. The sequence begins in the cycle after the write of 0 takes effect. Writing 1 alone never starts one.
- R2: While the start bit holds 1, the sequencer is held in reset. `eoc_n` reads 1 and no `conv_clk_en` pulse is produced.
- R3: With division D, `eoc_n` falls and `capture` pulses for exactly one cycle at the clock edge 1+12·D cycles after the edge that stored the start-bit 0.
- R4: `irq_flag` is set at completion and stays set until a write with `wr_irq_clr`=1. A completion in the same cycle as such a write wins. `irq` is high only when both `irq_flag` and `irq_en` are high.
- R5: Select codes give these divisions: 3'b100 gives 1, 3'b000 gives 2, 3'b101 gives 4, 3'b001 gives 8, 3'b110 gives 16 and 3'b010 gives 32. `conv_clk_en` pulses once every D cycles during a conversion.
- R6: Select codes 3'b111 and 3'b011 are undefined. Under these codes no `conv_clk_en` pulse occurs and a pending conversion makes no progress (`eoc_n` stays 1).
- R7: `too_fast` is 1 exactly when the select code is defined and D·1e9/SYS_HZ is below MIN_PERIOD_NS. With the defaults (8 MHz, 500 ns), this holds for D=1 and D=2.
- R8: The comparator bit present at the k-th bit-decision `conv_clk_en` pulse (the pulses numbered 2 to 11 of a conversion) is stored in `result[10-k]`, so the first decision lands in bit 9.
- R9: A complete start pulse during a conversion aborts it. Only the restarted conversion completes, timed from the new pulse.
- R10: After reset, `eoc_n`=1, `irq_flag`=0, `capture`=0, `conv_clk_en`=0 and `result`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Control register write strobe |
| wr_start | input | 1 | Start bit value written |
| wr_clk_sel | input | 3 | Conversion clock select code written |
| wr_irq_clr | input | 1 | With wr_en, clears the interrupt flag |
| irq_en | input | 1 | Interrupt enable |
| cmp_bit | input | 1 | Comparator decision from the analog core |
| eoc_n | output | 1 | Active-low end-of-conversion status |
| irq_flag | output | 1 | Sticky interrupt request flag |
| irq | output | 1 | Interrupt request, gated by irq_en |
| conv_clk_en | output | 1 | One-cycle conversion clock enable to the analog core |
| capture | output | 1 | One-cycle data capture strobe at completion |
| result | output | 10 | Conversion result |
| too_fast | output | 1 | Selected conversion clock period below minimum |

## Verification
Each result is due at a fixed cycle after its stimulus. The hold reset shows up one cycle after the write of 1. The start is seen one cycle after the write of 0. Completion comes 12·D cycles after that, so the driver logs its due cycle as the write cycle plus 2+12·D. The monitor compares the cycle count and the result word at the negative edge after each capture strobe. Any capture with no queued item, or at another cycle, counts as a mismatch. Flag and level checks are sampled at negative edges a known number of edges after the write that set them up.

// File: rtl/adc_seq_pkg.sv
// Package: shared widths and select-code decoding for the A/D sequencer.
// Assumes a 3-bit select code; undefined codes report invalid.
package adc_seq_pkg;
    localparam int SEL_W   = 3;
    localparam int LG_W    = 3;
    localparam int PHASE_W = 4;

    // Decode a select code into log2 of the division ratio.
    function automatic logic [LG_W-1:0] sel_log2(input logic [SEL_W-1:0] code);
        case (code)
            3'b100:  return 3'd0;
            3'b000:  return 3'd1;
            3'b101:  return 3'd2;
            3'b001:  return 3'd3;
            3'b110:  return 3'd4;
            3'b010:  return 3'd5;
            default: return 3'd0;
        endcase
    endfunction

    // Report whether a select code is defined.
    function automatic logic sel_valid(input logic [SEL_W-1:0] code);
        return !(code == 3'b111 || code == 3'b011);
    endfunction
endpackage

// File: rtl/adc_start_decoder.sv
// Start-bit decoder: stores the written start bit and the clock select.
// It produces a hold level while start is 1 and a one-cycle go pulse on 1->0.
// Assumes writes arrive as single-cycle wr_en strobes.
module adc_start_decoder
    import adc_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_start,
    input  logic [SEL_W-1:0] wr_clk_sel,
    output logic [SEL_W-1:0] sel_q,
    output logic             hold,
    output logic             go
);
    logic start_q;
    logic start_d1;

    // Register the software-written start bit and select field.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q <= 1'b0;
            sel_q   <= '0;
        end else if (wr_en) begin
            start_q <= wr_start;
            sel_q   <= wr_clk_sel;
        end
    end

    // Delay the start bit by one cycle for falling-edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) start_d1 <= 1'b0;
        else        start_d1 <= start_q;
    end

    // Hold while start is high; fire go on the completed high-low pulse.
    always_comb begin
        hold = start_q;
        go   = start_d1 && !start_q;
    end
endmodule

// File: rtl/adc_clk_prescaler.sv
// Prescaler: emits one tick every 2**n cycles while run is high.
// The counter restarts from zero on restart. Undefined codes give no ticks.
// It also flags divisions whose period falls below the minimum.
module adc_clk_prescaler
    import adc_seq_pkg::*;
#(
    parameter longint SYS_HZ        = 8_000_000,
    parameter longint MIN_PERIOD_NS = 500,
    parameter int     CNT_W         = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] sel,
    input  logic             run,
    input  logic             restart,
    output logic             tick,
    output logic             too_fast
);
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] div_m1;
    logic             valid;

    // Decode the terminal count and validity of the select code.
    always_comb begin
        valid  = sel_valid(sel);
        div_m1 = CNT_W'((32'd1 << sel_log2(sel)) - 32'd1);
        tick   = run && valid && (cnt == div_m1);
    end

    // Count system cycles inside one conversion-clock period.
    always_ff @(posedge clk) begin
        if (!rst_n || restart || !run || !valid) cnt <= '0;
        else if (cnt == div_m1)                  cnt <= '0;
        else                                     cnt <= cnt + 1'b1;
    end

    // Compare the selected period against the minimum allowed period.
    always_comb begin
        longint div_val;
        div_val  = longint'(1) << sel_log2(sel);
        too_fast = valid && ((div_val * 64'd1_000_000_000) < (MIN_PERIOD_NS * SYS_HZ));
    end
endmodule

// File: rtl/adc_conv_sequencer.sv
// Sequencer: one sample period, NBITS decision periods (MSB first) and one
// finish period. Each period ends on a prescaler tick. Hold wins over go,
// and go wins over ticks.
module adc_conv_sequencer
    import adc_seq_pkg::*;
#(
    parameter int NBITS = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold,
    input  logic             go,
    input  logic             tick,
    input  logic             cmp_bit,
    input  logic             irq_clr,
    output logic             busy,
    output logic             eoc_n,
    output logic             capture,
    output logic             irq_flag,
    output logic [NBITS-1:0] result
);
    localparam logic [PHASE_W-1:0] LAST = PHASE_W'(NBITS + 1);

    logic [PHASE_W-1:0] phase;
    logic               finish;

    // Completion condition for the final period.
    always_comb finish = busy && tick && !hold && !go && (phase == LAST);

    // Step phases, hold or restart, and close the conversion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            phase   <= '0;
            eoc_n   <= 1'b1;
            capture <= 1'b0;
        end else begin
            capture <= 1'b0;
            if (hold) begin
                busy  <= 1'b0;
                phase <= '0;
                eoc_n <= 1'b1;
            end else if (go) begin
                busy  <= 1'b1;
                phase <= '0;
                eoc_n <= 1'b1;
            end else if (finish) begin
                busy    <= 1'b0;
                eoc_n   <= 1'b0;
                capture <= 1'b1;
            end else if (busy && tick) begin
                phase <= phase + 1'b1;
            end
        end
    end

    // Latch one comparator bit at the end of each decision period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result <= '0;
        end else if (busy && tick && !hold && !go && phase >= 1 && phase <= PHASE_W'(NBITS)) begin
            result[NBITS - int'(phase)] <= cmp_bit;
        end
    end

    // Sticky interrupt flag: completion wins over a software clear.
    always_ff @(posedge clk) begin
        if (!rst_n)       irq_flag <= 1'b0;
        else if (finish)  irq_flag <= 1'b1;
        else if (irq_clr) irq_flag <= 1'b0;
    end
endmodule

// File: rtl/adc_seq_ctrl.sv
// Top: A/D start/end-of-conversion control. It joins the start decoder,
// the prescaler and the conversion sequencer. All outputs are registered
// except irq, conv_clk_en and too_fast.
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int     NBITS         = 10,
    parameter longint SYS_HZ        = 8_000_000,
    parameter longint MIN_PERIOD_NS = 500
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_start,
    input  logic [SEL_W-1:0] wr_clk_sel,
    input  logic             wr_irq_clr,
    input  logic             irq_en,
    input  logic             cmp_bit,
    output logic             eoc_n,
    output logic             irq_flag,
    output logic             irq,
    output logic             conv_clk_en,
    output logic             capture,
    output logic [NBITS-1:0] result,
    output logic             too_fast
);
    logic [SEL_W-1:0] sel_q;
    logic             hold;
    logic             go;
    logic             busy;
    logic             tick;

    adc_start_decoder u_dec (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_start(wr_start),
        .wr_clk_sel(wr_clk_sel), .sel_q(sel_q), .hold(hold), .go(go)
    );

    adc_clk_prescaler #(
        .SYS_HZ(SYS_HZ), .MIN_PERIOD_NS(MIN_PERIOD_NS)
    ) u_pre (
        .clk(clk), .rst_n(rst_n), .sel(sel_q), .run(busy),
        .restart(go || hold), .tick(tick), .too_fast(too_fast)
    );

    adc_conv_sequencer #(.NBITS(NBITS)) u_seq (
        .clk(clk), .rst_n(rst_n), .hold(hold), .go(go), .tick(tick),
        .cmp_bit(cmp_bit), .irq_clr(wr_en && wr_irq_clr), .busy(busy),
        .eoc_n(eoc_n), .capture(capture), .irq_flag(irq_flag), .result(result)
    );

    // Gate the interrupt request and expose the conversion clock enable.
    always_comb begin
        irq         = irq_flag && irq_en;
        conv_clk_en = tick;
    end
endmodule

// File: rtl/adc_seq_ctrl_chk.sv
// Checker bound to the top: timing relations between status, strobes
// and the stored select code.
bind adc_seq_ctrl adc_seq_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_start(wr_start),
    .sel_q(sel_q), .eoc_n(eoc_n), .capture(capture), .irq_flag(irq_flag),
    .conv_clk_en(conv_clk_en), .too_fast(too_fast)
);

module adc_seq_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic       wr_start,
    input logic [2:0] sel_q,
    input logic       eoc_n,
    input logic       capture,
    input logic       irq_flag,
    input logic       conv_clk_en,
    input logic       too_fast
);
    // Writing start=1 forces the status high two edges later.
    assert_hold_eoc_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_start) |-> ##2 eoc_n);

    // Undefined select codes never produce a conversion clock.
    assert_undef_no_clk_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_q == 3'b111 || sel_q == 3'b011) |-> !conv_clk_en);

    // Undefined select codes never raise the too-fast warning.
    assert_undef_not_fast_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_q == 3'b111 || sel_q == 3'b011) |-> !too_fast);

    // The capture strobe comes with a low status and a set flag.
    assert_capture_status_R4: assert property (@(posedge clk) disable iff (!rst_n)
        capture |-> (!eoc_n && irq_flag));

    // A falling status is always accompanied by the capture strobe.
    assert_fall_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(eoc_n) |-> capture);

    // The capture strobe lasts one cycle only.
    assert_capture_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        capture |=> !capture);
endmodule

// File: tb/adc_seq_ctrl_tb_top.sv
module adc_seq_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NB = 10;

    typedef struct {
        logic [NB-1:0] res;
        int            due;
        string         tag;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic          wr_start = 1'b0;
    logic [2:0]    wr_clk_sel = 3'b100;
    logic          wr_irq_clr = 1'b0;
    logic          irq_en = 1'b0;
    logic          cmp_bit;
    logic          eoc_n, irq_flag, irq, conv_clk_en, capture, too_fast;
    logic [NB-1:0] result;

    int            cyc = 0;
    int            tick_cnt = 0;
    int            n_chk = 0;
    int            n_bad = 0;
    int            n_cap = 0;
    logic [NB-1:0] pat = '0;
    exp_t          sb_q[$];

    adc_seq_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_start(wr_start),
        .wr_clk_sel(wr_clk_sel), .wr_irq_clr(wr_irq_clr), .irq_en(irq_en),
        .cmp_bit(cmp_bit), .eoc_n(eoc_n), .irq_flag(irq_flag), .irq(irq),
        .conv_clk_en(conv_clk_en), .capture(capture), .result(result),
        .too_fast(too_fast)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // Comparator stand-in: counts conversion clock pulses since a start write.
    always @(posedge clk) begin
        if (wr_en && wr_start) tick_cnt <= 0;
        else if (conv_clk_en)  tick_cnt <= tick_cnt + 1;
    end
    always_comb cmp_bit = (tick_cnt >= 1 && tick_cnt <= NB) ? pat[NB - tick_cnt] : 1'b0;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Monitor: pop and compare expected results on each capture strobe.
    always @(negedge clk) begin
        if (rst_n && capture) begin
            n_cap++;
            if (sb_q.size() == 0) begin
                check("R1 unexpected capture", 1, 0);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                check({e.tag, " R3 completion cycle"}, cyc, e.due);
                check({e.tag, " R8 result"}, result, e.res);
                check({e.tag, " R3 eoc_n low"}, eoc_n, 0);
            end
        end
    end

    task automatic wr(input logic st, input logic [2:0] sel, input logic clr);
        @(negedge clk);
        wr_en = 1'b1; wr_start = st; wr_clk_sel = sel; wr_irq_clr = clr;
        @(negedge clk);
        wr_en = 1'b0; wr_irq_clr = 1'b0;
    endtask

    function automatic int div_of(input logic [2:0] s);
        case (s)
            3'b100: return 1;  3'b000: return 2;  3'b101: return 4;
            3'b001: return 8;  3'b110: return 16; 3'b010: return 32;
            default: return 0;
        endcase
    endfunction

    // Driver: issue the closing write of 0 and queue the expected completion.
    task automatic finish_pulse(input logic [2:0] sel, input logic [NB-1:0] p, input string tag);
        exp_t e;
        @(negedge clk);
        pat = p;
        e.res = p; e.due = cyc + 2 + 12 * div_of(sel); e.tag = tag;
        sb_q.push_back(e);
        wr_en = 1'b1; wr_start = 1'b0; wr_clk_sel = sel;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic convert(input logic [2:0] sel, input logic [NB-1:0] p, input string tag);
        wr(1'b1, sel, 1'b0);
        finish_pulse(sel, p, tag);
    endtask

    task automatic wait_empty();
        for (int i = 0; i < 2000 && sb_q.size() != 0; i++) @(negedge clk);
        check("R3 completion seen", sb_q.size(), 0);
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_bad++;
        n_chk++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int pulses;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        check("R10 eoc_n", eoc_n, 1);
        check("R10 irq_flag", irq_flag, 0);
        check("R10 capture", capture, 0);
        check("R10 conv_clk_en", conv_clk_en, 0);
        check("R10 result", result, 0);

        // R7 warning per code at 8 MHz and 500 ns
        wr(1'b0, 3'b100, 1'b0); check("R7 code100", too_fast, 1);
        wr(1'b0, 3'b000, 1'b0); check("R7 code000", too_fast, 1);
        wr(1'b0, 3'b101, 1'b0); check("R7 code101", too_fast, 0);
        wr(1'b0, 3'b010, 1'b0); check("R7 code010", too_fast, 0);
        wr(1'b0, 3'b111, 1'b0); check("R7 code111", too_fast, 0);
        repeat (5) @(negedge clk);
        check("R1 write 0 alone no start", eoc_n, 1);

        // R2 hold, then R1 start on release, R5 D=1
        wr(1'b1, 3'b100, 1'b0);
        repeat (40) @(negedge clk);
        check("R2 held eoc_n", eoc_n, 1);
        check("R2 no clock pulses", tick_cnt, 0);
        check("R1 no capture while high", n_cap, 0);
        finish_pulse(3'b100, 10'h2A5, "R5 div1");
        wait_empty();

        // R4 flag without enable, then enable, then clear
        check("R4 flag set", irq_flag, 1);
        check("R4 irq gated off", irq, 0);
        irq_en = 1'b1;
        @(negedge clk);
        check("R4 irq enabled", irq, 1);
        wr(1'b0, 3'b100, 1'b1);
        check("R4 flag cleared", irq_flag, 0);
        check("R4 irq after clear", irq, 0);

        // R5 other divisions and R8 patterns
        convert(3'b000, 10'h3FF, "R5 div2");
        wait_empty();
        convert(3'b101, 10'h001, "R5 div4");
        wait_empty();
        convert(3'b001, 10'h200, "R5 div8");
        wait_empty();
        convert(3'b010, 10'h155, "R5 div32");
        wait_empty();

        // R5 pulse spacing under D=8 after start
        wr(1'b1, 3'b001, 1'b0);
        finish_pulse(3'b001, 10'h0F0, "R5 spacing");
        repeat (8 * 5 + 1) @(negedge clk);
        check("R5 five pulses in 5*D", tick_cnt, 5);
        wait_empty();

        // R6 undefined code: no progress
        convert(3'b110, 10'h0C3, "R6 recovery");
        wr(1'b0, 3'b111, 1'b0);
        pulses = tick_cnt;
        repeat (300) @(negedge clk);
        check("R6 no pulses", tick_cnt, pulses);
        check("R6 eoc_n stays", eoc_n, 1);
        sb_q.delete();
        wr(1'b1, 3'b011, 1'b0);
        wr(1'b0, 3'b011, 1'b0);
        repeat (300) @(negedge clk);
        check("R6 code011 no pulses", tick_cnt, 0);
        check("R6 code011 eoc_n", eoc_n, 1);

        // R9 abort and restart
        convert(3'b101, 10'h123, "R9 first");
        repeat (20) @(negedge clk);
        sb_q.delete();
        convert(3'b101, 10'h2DC, "R9 restart");
        wait_empty();
        repeat (100) @(negedge clk);
        check("R9 single capture total", n_cap, 7);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule